// File: doc/BRIEF.md
# Piecewise-Sampled Function Table

This block returns the value of a fixed nonlinear function for a signed fixed-point input by looking it up in a set of small constant tables. The input range is cut into contiguous regions. Each region has its own table and its own sampling step, and every step is a power of two. Where the function is steep the step is short. Where it is flat the step is long. This keeps the total table storage small while the error stays tight where it matters.

A region selector compares the input with the ordered region bounds and marks exactly one region. That region's table converts the offset of the input from the region start into an entry index. The outputs of all tables are merged into one value, which is registered on the clock. Inputs outside the covered range clamp to the first or the last stored entry.

The table contents are computed at elaboration from the parameters. Two function shapes are available: a scaled reciprocal, which is steep at the low end, and a scaled square. A parameter picks the shape. There is no runtime reprogramming and no interpolation.

Top module: `seglut_eval`

## Requirements
- R1: The region chosen for an input is the first region, in ascending bound order, whose upper bound is greater than the input. With the defaults, the bounds are -512, -256, 0, 512 and 1536, and these give four regions.
- R2: Within the chosen region, the entry index is (input - region start) >> step exponent. The output is the function evaluated at the sample point region start + (index << step exponent).
- R3: Each region uses its own step exponent. The defaults are 3, 4, 5 and 6 from the lowest region to the highest. Two inputs in the same step give the same output, and the first input of the next step gives the next entry.
- R4: An input below the lowest bound produces the first entry of the lowest region. That entry is the function at the lowest bound.
- R5: An input at or above the highest bound produces the last entry of the highest region. With the defaults, that entry is the function at 1472.
- R6: The output changes exactly one clock edge after the input. Between the input change and that edge, the output keeps its previous value.
- R7: A synchronous active-high reset clears the output to zero, whatever the input is.
- R8: With FUNC=0, the function is SCALE / (s - lowest bound + BIAS). The defaults are SCALE=1048576 and BIAS=64. The result is an unsigned integer quotient, clipped to the all-ones value of OUT_W bits.
- R9: With FUNC=1, the function is ((s - lowest bound) squared) >> SQ_SHIFT. The default is SQ_SHIFT=6. The result is clipped to the all-ones value of OUT_W bits.
- R10: For every input, exactly one region is marked as selected. An input is never flagged as both below and above the covered range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the output register updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset; clears the output |
| x_in | input | IN_W | Signed two's-complement function argument |
| y_out | output | OUT_W | Unsigned registered function value |

## Verification
The inputs are chosen to tell the possible faults apart:
- The first and last input of a step show whether the index shift uses the right step exponent.
- The last input of one region and the first input of the next separate a correct strict upper-bound compare from an off-by-one compare.
- Inputs far below and far above the covered range, and exactly at the highest bound, show whether saturation clamps to the end entries rather than wrapping the index.
- The same sequence is applied to a reciprocal instance and a square instance. The steep and the rising shapes expose a table fill or a merge that takes data from the wrong region.

// File: rtl/seglut_pkg.sv
package seglut_pkg;

   localparam int FN_RECIP  = 0;
   localparam int FN_SQUARE = 1;

   // Clip a non-negative value to the largest unsigned number of w bits.
   function automatic longint clip_to(input longint v, input int w);
      longint top;
      top = (longint'(1) <<< w) - 1;
      if (v < 0)   return 0;
      if (v > top) return top;
      return v;
   endfunction

   // Scaled reciprocal measured from the table origin.
   function automatic longint recip_at(input int s, input int origin,
                                       input longint scale, input int bias,
                                       input int w);
      longint den;
      den = longint'(s) - longint'(origin) + longint'(bias);
      if (den <= 0) return clip_to(-1 * 0 + (longint'(1) <<< w), w);
      return clip_to(scale / den, w);
   endfunction

   // Scaled square measured from the table origin.
   function automatic longint square_at(input int s, input int origin,
                                        input int shift, input int w);
      longint d;
      d = longint'(s) - longint'(origin);
      return clip_to((d * d) >>> shift, w);
   endfunction

endpackage

// File: rtl/seglut_region_sel.sv
module seglut_region_sel #(
   parameter int IN_W = 12,
   parameter int NREG = 4,
   parameter int BOUND [NREG+1] = '{-512, -256, 0, 512, 1536}
) (
   input  logic signed [IN_W-1:0] x,
   output logic [NREG-1:0]        hit,
   output logic                   below,
   output logic                   above
);

   int  xv;
   logic found;

   always_comb begin
      xv    = int'(x);
      below = (xv < BOUND[0]);
      above = (xv >= BOUND[NREG]);
      hit   = '0;
      found = 1'b0;
      // first region whose upper bound exceeds the input
      for (int r = 0; r < NREG; r++) begin
         if (!found && (xv < BOUND[r+1])) begin
            hit[r] = 1'b1;
            found  = 1'b1;
         end
      end
      if (!found) hit[NREG-1] = 1'b1;
   end

endmodule

// File: rtl/seglut_region_rom.sv
module seglut_region_rom #(
   parameter int     IN_W     = 12,
   parameter int     OUT_W    = 16,
   parameter int     LO       = 0,
   parameter int     HI       = 256,
   parameter int     STEP     = 4,
   parameter int     ORIGIN   = 0,
   parameter int     FUNC     = 0,
   parameter longint SCALE    = 1048576,
   parameter int     BIAS     = 64,
   parameter int     SQ_SHIFT = 6,
   parameter bit     CLAMP_LO = 1'b0,
   parameter bit     CLAMP_HI = 1'b0
) (
   input  logic signed [IN_W-1:0] x,
   input  logic                   hit,
   input  logic                   below,
   input  logic                   above,
   output logic [OUT_W-1:0]       data
);

   localparam int SPAN  = HI - LO;
   localparam int DEPTH = SPAN >>> STEP;
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [OUT_W-1:0] rom [DEPTH];

   for (genvar k = 0; k < DEPTH; k++) begin : g_entry
      localparam int SAMPLE = LO + (k <<< STEP);
      if (FUNC == seglut_pkg::FN_SQUARE) begin : g_sq
         assign rom[k] = OUT_W'(seglut_pkg::square_at(SAMPLE, ORIGIN,
                                                      SQ_SHIFT, OUT_W));
      end else begin : g_rc
         assign rom[k] = OUT_W'(seglut_pkg::recip_at(SAMPLE, ORIGIN,
                                                     SCALE, BIAS, OUT_W));
      end
   end

   int           off;
   logic [IDX_W-1:0] idx;

   always_comb begin
      off = int'(x) - LO;
      if (CLAMP_LO && below)
         idx = '0;
      else if (CLAMP_HI && above)
         idx = IDX_W'(DEPTH - 1);
      else if (off >= 0 && off < SPAN)
         idx = IDX_W'(off >>> STEP);
      else
         idx = '0;
   end

   assign data = hit ? rom[idx] : '0;

endmodule

// File: rtl/seglut_merge.sv
module seglut_merge #(
   parameter int OUT_W = 16,
   parameter int NREG  = 4
) (
   input  logic [OUT_W-1:0] parts [NREG],
   output logic [OUT_W-1:0] y
);

   always_comb begin
      y = '0;
      for (int r = 0; r < NREG; r++) y = y | parts[r];
   end

endmodule

// File: rtl/seglut_eval.sv
module seglut_eval #(
   parameter int     IN_W     = 12,
   parameter int     OUT_W    = 16,
   parameter int     NREG     = 4,
   parameter int     BOUND [NREG+1] = '{-512, -256, 0, 512, 1536},
   parameter int     STEP_EXP [NREG] = '{3, 4, 5, 6},
   parameter int     FUNC     = 0,
   parameter longint SCALE    = 1048576,
   parameter int     BIAS     = 64,
   parameter int     SQ_SHIFT = 6
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic signed [IN_W-1:0] x_in,
   output logic [OUT_W-1:0]       y_out
);

   localparam int X_MIN = -(1 <<< (IN_W - 1));
   localparam int X_MAX = (1 <<< (IN_W - 1)) - 1;

   // elaboration-time parameter checks
   if (FUNC != seglut_pkg::FN_RECIP && FUNC != seglut_pkg::FN_SQUARE) begin : g_bad_fn
      $error("seglut_eval: FUNC selects no known shape");
   end
   if (BOUND[0] < X_MIN || BOUND[NREG] > X_MAX + 1) begin : g_bad_rng
      $error("seglut_eval: bounds outside the input range");
   end
   for (genvar r = 0; r < NREG; r++) begin : g_cfg_chk
      if (BOUND[r+1] <= BOUND[r]) begin : g_order
         $error("seglut_eval: bounds must ascend strictly");
      end
      if (((BOUND[r+1] - BOUND[r]) % (1 <<< STEP_EXP[r])) != 0) begin : g_align
         $error("seglut_eval: region span not a multiple of its step");
      end
   end

   logic [NREG-1:0]  reg_hit;
   logic             in_below;
   logic             in_above;
   logic [OUT_W-1:0] parts [NREG];
   logic [OUT_W-1:0] merged;
   logic [OUT_W-1:0] y_q;

   seglut_region_sel #(
      .IN_W  (IN_W),
      .NREG  (NREG),
      .BOUND (BOUND)
   ) u_sel (
      .x     (x_in),
      .hit   (reg_hit),
      .below (in_below),
      .above (in_above)
   );

   for (genvar r = 0; r < NREG; r++) begin : g_region
      seglut_region_rom #(
         .IN_W     (IN_W),
         .OUT_W    (OUT_W),
         .LO       (BOUND[r]),
         .HI       (BOUND[r+1]),
         .STEP     (STEP_EXP[r]),
         .ORIGIN   (BOUND[0]),
         .FUNC     (FUNC),
         .SCALE    (SCALE),
         .BIAS     (BIAS),
         .SQ_SHIFT (SQ_SHIFT),
         .CLAMP_LO (r == 0),
         .CLAMP_HI (r == NREG - 1)
      ) u_rom (
         .x     (x_in),
         .hit   (reg_hit[r]),
         .below (in_below),
         .above (in_above),
         .data  (parts[r])
      );
   end

   seglut_merge #(
      .OUT_W (OUT_W),
      .NREG  (NREG)
   ) u_merge (
      .parts (parts),
      .y     (merged)
   );

   always_ff @(posedge clk) begin
      if (rst) y_q <= '0;
      else     y_q <= merged;
   end

   assign y_out = y_q;

endmodule

// File: rtl/seglut_eval_chk.sv
module seglut_eval_chk #(
   parameter int IN_W  = 12,
   parameter int OUT_W = 16,
   parameter int NREG  = 4
) (
   input logic                   clk,
   input logic                   rst,
   input logic signed [IN_W-1:0] x_in,
   input logic [OUT_W-1:0]       y_q,
   input logic [NREG-1:0]        reg_hit,
   input logic                   in_below,
   input logic                   in_above
);

   logic [1:0] warm_cnt = '0;
   logic       armed    = 1'b0;
   logic       warm;

   always_ff @(posedge clk) begin
      armed <= 1'b1;
      if (rst)                  warm_cnt <= '0;
      else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
   end

   assign warm = (warm_cnt >= 2'd2);

   // R10
   one_region_chk: assert property (@(posedge clk) disable iff (rst)
      $countones(reg_hit) == 1);

   // R10
   sat_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(in_below && in_above));

   // R4
   low_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (warm && in_below && $past(in_below)) |=> $stable(y_q));

   // R5
   high_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (warm && in_above && $past(in_above)) |=> $stable(y_q));

   // R6
   steady_in_chk: assert property (@(posedge clk) disable iff (rst)
      (warm && x_in == $past(x_in)) |=> $stable(y_q));

   // R7
   always @(posedge clk) begin
      if (armed && $past(rst)) begin
         reset_zero_chk: assert (y_q == '0);
      end
   end

endmodule

bind seglut_eval seglut_eval_chk #(
   .IN_W  (IN_W),
   .OUT_W (OUT_W),
   .NREG  (NREG)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .x_in     (x_in),
   .y_q      (y_out),
   .reg_hit  (reg_hit),
   .in_below (in_below),
   .in_above (in_above)
);

// File: tb/sim_seglut_eval.sv
module sim_seglut_eval;

   localparam int IN_W  = 12;
   localparam int OUT_W = 16;

   logic                   clk = 1'b0;
   logic                   rst = 1'b1;
   logic signed [IN_W-1:0] x_in = '0;
   logic [OUT_W-1:0]       y_out;
   logic [OUT_W-1:0]       y_sq;

   int  errors = 0;
   int  checks = 0;
   bit  done   = 1'b0;
   int  prev_rc;
   int  prev_sq;

   always #4 clk = ~clk;   // 125 MHz

   seglut_eval u0 (.clk(clk), .rst(rst), .x_in(x_in), .y_out(y_out));

   seglut_eval #(.FUNC(1)) u1 (.clk(clk), .rst(rst), .x_in(x_in), .y_out(y_sq));

   // reference shapes taken from R8 and R9
   function automatic int ref_rc(input int s);
      longint v;
      v = 64'd1048576 / longint'(s + 512 + 64);
      if (v > 65535) v = 65535;
      return int'(v);
   endfunction

   function automatic int ref_sq(input int s);
      longint d, v;
      d = longint'(s + 512);
      v = (d * d) >>> 6;
      if (v > 65535) v = 65535;
      return int'(v);
   endfunction

   typedef struct packed {
      int x;     // stimulus
      int s;     // expected sample point
      int req;   // requirement number
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VECS [NV] = '{
      '{-512,  -512, 1},   // R1 first input of lowest region
      '{-505,  -512, 3},   // R3 same step as -512
      '{-504,  -504, 3},   // R3 next step of region 0
      '{-257,  -264, 2},   // R2 last input of region 0
      '{-256,  -256, 1},   // R1 boundary into region 1
      '{-1,    -16,  2},   // R2 step 16 index
      '{0,     0,    1},   // R1 boundary into region 2
      '{31,    0,    3},   // R3 step 32 still entry 0
      '{32,    32,   3},   // R3 next entry
      '{511,   480,  2},   // R2 last input of region 2
      '{512,   512,  1},   // R1 boundary into region 3
      '{600,   576,  8},   // R8 reciprocal value
      '{1535,  1472, 2},   // R2 last covered input
      '{1536,  1472, 5},   // R5 exactly at highest bound
      '{2047,  1472, 5},   // R5 top of input range
      '{-513,  -512, 4},   // R4 just below lowest bound
      '{-2048, -512, 4}    // R4 bottom of input range
   };

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic apply(input int xv, input int s, input int req);
      @(negedge clk);
      x_in = IN_W'(xv);
      #2;
      // R6: nothing moves before the next edge
      check(int'(y_out) == prev_rc, "R6", "held before edge", int'(y_out), prev_rc);
      @(negedge clk);
      check(int'(y_out) == ref_rc(s), $sformatf("R%0d", req),
            $sformatf("recip x=%0d", xv), int'(y_out), ref_rc(s));
      // R9 square shape on the same sample point
      check(int'(y_sq) == ref_sq(s), "R9",
            $sformatf("square x=%0d", xv), int'(y_sq), ref_sq(s));
      prev_rc = ref_rc(s);
      prev_sq = ref_sq(s);
   endtask

   initial begin
      // R7: reset clears output while input moves
      repeat (2) @(negedge clk);
      x_in = IN_W'(600);
      @(negedge clk);
      check(y_out == '0, "R7", "recip in reset", int'(y_out), 0);
      check(y_sq == '0, "R7", "square in reset", int'(y_sq), 0);
      x_in = '0;
      rst  = 1'b0;
      @(negedge clk);
      check(int'(y_out) == ref_rc(0), "R1", "first value after reset", int'(y_out), ref_rc(0));
      prev_rc = ref_rc(0);
      prev_sq = ref_sq(0);

      for (int i = 0; i < NV; i++) apply(VECS[i].x, VECS[i].s, VECS[i].req);

      // R3: adjacent steps in region 0 must give distinct entries
      check(ref_rc(-512) != ref_rc(-504), "R3", "step entries distinct",
            ref_rc(-512), ref_rc(-504));

      // R7: mid-run reset with a live input
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check(y_out == '0, "R7", "mid-run reset", int'(y_out), 0);
      rst = 1'b0;
      @(negedge clk);
      check(int'(y_out) == ref_rc(-512), "R4", "after reset low clamp",
            int'(y_out), ref_rc(-512));

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule